// File: doc/BRIEF.md
# Serial Programming Address Counter and Row Write Buffer

This block sits behind a serial programming port and owns the addressing and staging side of non-volatile memory programming. It keeps a 12-bit address that only counts upward over a 4096-word programming space. The lower half of that space (0x000 to 0x7FF) is user memory and the upper half (0x800 to 0xFFF) is configuration memory. Words presented by the host are staged in a four-slot row buffer. The slot is chosen by the two low address bits. A programming strobe then turns the buffer into a single registered row write toward the memory array.

Access to configuration space is gated. Only the four identification words at 0x800 to 0x803 are usable. The configuration word at 0xFFF can be reached only between mode entry and the first address increment. Every other configuration address reads as all ones and is never written. In configuration space a programming strobe writes one word, not a whole row.

The host drives one command per cycle: enter, increment, load or program. The memory array is external. It receives a row index, a four-bit word mask and the four staged words. The read path returns the array's word at the current address, or all ones where access is not allowed.

Top module: `prg_row_writer`

## Requirements
- R1: After reset or an enter command, the address is 0xFFF, the configuration word is reachable and all four buffer slots hold 0xFFF (blank).
- R2: An increment adds one to the address. 0x7FF steps to 0x800, and 0xFFF wraps to 0x000.
- R3: After any increment, address 0xFFF is locked until the next reset or enter command. While locked, 0xFFF reads as 0xFFF and a program command there writes nothing.
- R4: A load command stores the load data in buffer slot address[1:0] and leaves the address unchanged.
- R5: A program command in user space (address bit 11 = 0) gives, on the next cycle, one write with row = address[11:2] and mask = 4'b1111. Slot i of the buffer appears on wr_data_o bits [12i+11:12i].
- R6: A program command at 0x800 to 0x803, or at an unlocked 0xFFF, gives one write whose mask is one-hot at bit address[1:0].
- R7: A program command at 0x804 to 0xFFE gives no write.
- R8: Every program command, with or without a write, returns all buffer slots to 0xFFF.
- R9: rd_data_o equals rd_data_i (the array word at addr_o) for user space, 0x800 to 0x803, and an unlocked 0xFFF. Otherwise it is 0xFFF.
- R10: When several command inputs are high together, only one acts, in the priority enter, increment, load, program.
- R11: wr_en_o is high for exactly the cycle after each program command that writes, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_i | input | 1 | Enter programming mode |
| incr_i | input | 1 | Increment address |
| load_i | input | 1 | Stage load_data_i in the row buffer |
| prog_i | input | 1 | Begin programming |
| load_data_i | input | 12 | Word to stage |
| addr_o | output | 12 | Current address, also the array read address |
| rd_data_i | input | 12 | Array word at addr_o |
| rd_data_o | output | 12 | Gated read data |
| wr_en_o | output | 1 | Row write strobe |
| wr_row_o | output | 10 | Row index (address bits 11:2) |
| wr_mask_o | output | 4 | Words of the row to write |
| wr_data_o | output | 48 | Four staged words, slot 0 lowest |

## Verification
On every cycle, the assertions check the following:
- the counter's single-step behaviour and the reset target on entry;
- that the address is held during loads;
- the mask shape for user-space and configuration-space writes;
- the suppression of writes at unavailable addresses;
- the all-ones read at a locked 0xFFF;
- that each write follows a program command.

Some behaviour needs the bench scenarios instead. These cover:
- which word landed in which array location after row and single-word programming, read back through the gated path;
- the buffer returning to blank;
- the two boundary crossings at 0x7FF and 0xFFF, reached by long increment runs;
- the lock surviving a full wrap back to 0xFFF;
- the dropped lower-priority command when inputs collide.

// File: rtl/prg_pkg.sv
package prg_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_ENTER = 3'd1,
    CMD_INC   = 3'd2,
    CMD_LOAD  = 3'd3,
    CMD_PROG  = 3'd4
  } cmd_e;

  // Single command per cycle: enter > increment > load > program.
  function automatic cmd_e prg_decode(input logic en, input logic inc,
                                      input logic ld, input logic pg);
    if (en)       return CMD_ENTER;
    else if (inc) return CMD_INC;
    else if (ld)  return CMD_LOAD;
    else if (pg)  return CMD_PROG;
    else          return CMD_IDLE;
  endfunction

endpackage

// File: rtl/prg_addr_ctr.sv
module prg_addr_ctr
  import prg_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd,
  output logic [AW-1:0] addr,
  output logic          cfg_locked
);

  // Plain modulo step: 0x7FF -> 0x800 and top -> 0 fall out of the width.
  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic [AW-1:0] addr_q;
  logic          lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '1;
      lock_q <= 1'b0;
    end else begin
      case (cmd)
        CMD_ENTER: begin
          addr_q <= '1;
          lock_q <= 1'b0;
        end
        CMD_INC: begin
          addr_q <= next_addr(addr_q);
          lock_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign addr       = addr_q;
  assign cfg_locked = lock_q;

endmodule

// File: rtl/prg_row_latch.sv
module prg_row_latch
  import prg_pkg::*;
#(
  parameter int DW = 12,
  parameter int SB = 2,
  localparam int NS = 1 << SB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [SB-1:0]    slot,
  input  logic [DW-1:0]    din,
  output logic [NS*DW-1:0] row_q
);

  for (genvar i = 0; i < NS; i++) begin : g_slot
    logic [DW-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '1;
      else if (cmd == CMD_ENTER || cmd == CMD_PROG)
        word_q <= '1;
      else if (cmd == CMD_LOAD && slot == SB'(i))
        word_q <= din;
    end

    assign row_q[i*DW +: DW] = word_q;
  end

endmodule

// File: rtl/prg_access_gate.sv
module prg_access_gate #(
  parameter int AW = 12,
  parameter int DW = 12,
  parameter int SB = 2,
  localparam int NS = 1 << SB,
  localparam int RW = AW - SB
) (
  input  logic [AW-1:0] addr,
  input  logic          cfg_locked,
  input  logic [DW-1:0] rd_data_i,
  output logic          avail,
  output logic [NS-1:0] wmask,
  output logic [DW-1:0] rd_data_o
);

  function automatic logic in_user(input logic [AW-1:0] a);
    return !a[AW-1];
  endfunction

  function automatic logic in_id_row(input logic [AW-1:0] a);
    return a[AW-1:SB] == {1'b1, {(RW-1){1'b0}}};
  endfunction

  function automatic logic is_cfg_word(input logic [AW-1:0] a);
    return &a;
  endfunction

  function automatic logic [NS-1:0] word_mask(input logic [AW-1:0] a);
    if (in_user(a)) return '1;
    else            return NS'(1) << a[SB-1:0];
  endfunction

  assign avail = in_user(addr) || in_id_row(addr) ||
                 (is_cfg_word(addr) && !cfg_locked);
  assign wmask     = word_mask(addr);
  assign rd_data_o = avail ? rd_data_i : '1;

endmodule

// File: rtl/prg_row_writer.sv
module prg_row_writer
  import prg_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 12,
  parameter int SB = 2,
  localparam int NS = 1 << SB,
  localparam int RW = AW - SB,
  localparam int LW = NS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_i,
  input  logic          incr_i,
  input  logic          load_i,
  input  logic          prog_i,
  input  logic [DW-1:0] load_data_i,
  output logic [AW-1:0] addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          wr_en_o,
  output logic [RW-1:0] wr_row_o,
  output logic [NS-1:0] wr_mask_o,
  output logic [LW-1:0] wr_data_o
);

  // Named internal events, observed by the bound checker.
  cmd_e          cmd;
  logic [AW-1:0] addr;
  logic          cfg_locked;
  logic          avail;
  logic [NS-1:0] wmask;
  logic [LW-1:0] row_q;
  logic          prog_fire;

  assign cmd       = prg_decode(enter_i, incr_i, load_i, prog_i);
  assign prog_fire = (cmd == CMD_PROG) && avail;

  prg_addr_ctr #(.AW(AW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .addr       (addr),
    .cfg_locked (cfg_locked)
  );

  prg_row_latch #(.DW(DW), .SB(SB)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .slot  (addr[SB-1:0]),
    .din   (load_data_i),
    .row_q (row_q)
  );

  prg_access_gate #(.AW(AW), .DW(DW), .SB(SB)) u_gate (
    .addr       (addr),
    .cfg_locked (cfg_locked),
    .rd_data_i  (rd_data_i),
    .avail      (avail),
    .wmask      (wmask),
    .rd_data_o  (rd_data_o)
  );

  logic          wr_en_q;
  logic [RW-1:0] wr_row_q;
  logic [NS-1:0] wr_mask_q;
  logic [LW-1:0] wr_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q   <= 1'b0;
      wr_row_q  <= '0;
      wr_mask_q <= '0;
      wr_data_q <= '1;
    end else begin
      wr_en_q <= prog_fire;
      if (prog_fire) begin
        wr_row_q  <= addr[AW-1:SB];
        wr_mask_q <= wmask;
        wr_data_q <= row_q;
      end
    end
  end

  assign addr_o    = addr;
  assign wr_en_o   = wr_en_q;
  assign wr_row_o  = wr_row_q;
  assign wr_mask_o = wr_mask_q;
  assign wr_data_o = wr_data_q;

endmodule

// File: rtl/prg_row_writer_chk.sv
module prg_row_writer_chk
  import prg_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 12,
  parameter int SB = 2,
  localparam int NS = 1 << SB,
  localparam int RW = AW - SB
) (
  input logic          clk,
  input logic          rst_n,
  input cmd_e          cmd,
  input logic          avail,
  input logic          cfg_locked,
  input logic [AW-1:0] addr_o,
  input logic [DW-1:0] rd_data_o,
  input logic          wr_en_o,
  input logic [RW-1:0] wr_row_o,
  input logic [NS-1:0] wr_mask_o
);

  assert_entry_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_ENTER |=> (&addr_o) && !cfg_locked);

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_INC |=> addr_o == AW'($past(addr_o) + AW'(1)));

  assert_locked_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_locked && (&addr_o)) |-> (&rd_data_o));

  assert_load_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_LOAD |=> $stable(addr_o));

  assert_user_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !wr_row_o[RW-1]) |-> (&wr_mask_o));

  assert_cfg_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_row_o[RW-1]) |-> $countones(wr_mask_o) == 1);

  assert_no_bad_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PROG && !avail) |=> !wr_en_o);

  assert_wr_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(cmd == CMD_PROG));

endmodule

bind prg_row_writer prg_row_writer_chk #(.AW(AW), .DW(DW), .SB(SB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd        (cmd),
  .avail      (avail),
  .cfg_locked (cfg_locked),
  .addr_o     (addr_o),
  .rd_data_o  (rd_data_o),
  .wr_en_o    (wr_en_o),
  .wr_row_o   (wr_row_o),
  .wr_mask_o  (wr_mask_o)
);

// File: tb/prg_row_writer_tb.sv
module prg_row_writer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enter_i = 1'b0, incr_i = 1'b0, load_i = 1'b0, prog_i = 1'b0;
  logic [11:0] load_data_i = '0;
  logic [11:0] addr_o, rd_data_i, rd_data_o;
  logic        wr_en_o;
  logic [9:0]  wr_row_o;
  logic [3:0]  wr_mask_o;
  logic [47:0] wr_data_o;
  logic        preset = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  prg_row_writer u_dut (
    .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .incr_i(incr_i),
    .load_i(load_i), .prog_i(prog_i), .load_data_i(load_data_i),
    .addr_o(addr_o), .rd_data_i(rd_data_i), .rd_data_o(rd_data_o),
    .wr_en_o(wr_en_o), .wr_row_o(wr_row_o), .wr_mask_o(wr_mask_o),
    .wr_data_o(wr_data_o)
  );

  // Behavioural array: one writer process.
  logic [11:0] mem [4096];
  always @(posedge clk) begin
    if (preset) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 12'h000;
      mem[12'hFFF] <= 12'hA5C;
      mem[12'h804] <= 12'h123;
    end else if (wr_en_o) begin
      for (int k = 0; k < 4; k++)
        if (wr_mask_o[k]) mem[{wr_row_o, 2'(k)}] <= wr_data_o[k*12 +: 12];
    end
  end
  assign rd_data_i = mem[addr_o];

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic inc, input logic ld,
                      input logic pg, input logic [11:0] d);
    enter_i = en; incr_i = inc; load_i = ld; prog_i = pg; load_data_i = d;
    @(posedge clk);
    @(negedge clk);
    enter_i = 0; incr_i = 0; load_i = 0; prog_i = 0;
  endtask

  // {op[2:0], data[11:0], exp_addr[11:0], exp_wr, exp_mask[3:0]}
  // op: 0 idle, 1 enter, 2 increment, 3 load, 4 program
  localparam int NV = 15;
  localparam logic [31:0] VEC [NV] = '{
    {3'd3, 12'h3C1, 12'hFFF, 1'b0, 4'h0},
    {3'd4, 12'h000, 12'hFFF, 1'b1, 4'h8},
    {3'd2, 12'h000, 12'h000, 1'b0, 4'h0},
    {3'd3, 12'h111, 12'h000, 1'b0, 4'h0},
    {3'd2, 12'h000, 12'h001, 1'b0, 4'h0},
    {3'd3, 12'h222, 12'h001, 1'b0, 4'h0},
    {3'd2, 12'h000, 12'h002, 1'b0, 4'h0},
    {3'd3, 12'h333, 12'h002, 1'b0, 4'h0},
    {3'd2, 12'h000, 12'h003, 1'b0, 4'h0},
    {3'd3, 12'h444, 12'h003, 1'b0, 4'h0},
    {3'd4, 12'h000, 12'h003, 1'b1, 4'hF},
    {3'd2, 12'h000, 12'h004, 1'b0, 4'h0},
    {3'd3, 12'h555, 12'h004, 1'b0, 4'h0},
    {3'd4, 12'h000, 12'h004, 1'b1, 4'hF},
    {3'd1, 12'h000, 12'hFFF, 1'b0, 4'h0}
  };

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    repeat (3) @(negedge clk);
    preset = 1'b0;
    rst_n  = 1'b1;
    @(negedge clk);
    check("R1 reset addr", addr_o, 12'hFFF);
    check("R11 reset wr_en", wr_en_o, 0);
    check("R1 R9 cfg word readable", rd_data_o, 12'hA5C);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op;
      op = VEC[v][31:29];
      step(op == 3'd1, op == 3'd2, op == 3'd3, op == 3'd4, VEC[v][28:17]);
      check($sformatf("R2 R4 vec%0d addr", v), addr_o, VEC[v][16:5]);
      check($sformatf("R11 vec%0d wr_en", v), wr_en_o, VEC[v][4]);
      if (VEC[v][4]) begin
        check($sformatf("R5 R6 vec%0d mask", v), wr_mask_o, VEC[v][3:0]);
        check($sformatf("R5 vec%0d row", v), wr_row_o, VEC[v][16:7]);
      end
    end

    // Read back through the gated path.
    check("R6 R9 cfg word written", rd_data_o, 12'h3C1);
    step(0, 1, 0, 0, 0); check("R5 slot0", rd_data_o, 12'h111);
    step(0, 1, 0, 0, 0); check("R5 slot1", rd_data_o, 12'h222);
    step(0, 1, 0, 0, 0); check("R5 slot2", rd_data_o, 12'h333);
    step(0, 1, 0, 0, 0); check("R5 slot3", rd_data_o, 12'h444);
    step(0, 1, 0, 0, 0); check("R5 row1 slot0", rd_data_o, 12'h555);
    step(0, 1, 0, 0, 0); check("R8 row1 slot1 blank", rd_data_o, 12'hFFF);

    while (addr_o != 12'h7FF) step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0); check("R2 user top to cfg", addr_o, 12'h800);
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 12'h00B);
    step(0, 0, 0, 1, 0);
    check("R6 id wr_en", wr_en_o, 1);
    check("R6 id mask", wr_mask_o, 4'b0010);
    check("R6 id row", wr_row_o, 10'h200);
    check("R6 id data", wr_data_o[23:12], 12'h00B);
    step(0, 0, 0, 0, 0);
    check("R11 single pulse", wr_en_o, 0);
    check("R9 id readback", rd_data_o, 12'h00B);

    repeat (3) step(0, 1, 0, 0, 0);
    check("R2 addr 804", addr_o, 12'h804);
    step(0, 0, 1, 0, 12'h777);
    step(0, 0, 0, 1, 0);
    check("R7 no write at 804", wr_en_o, 0);
    check("R9 unavailable reads ones", rd_data_o, 12'hFFF);

    while (addr_o != 12'hFFF) step(0, 1, 0, 0, 0);
    check("R3 locked cfg reads ones", rd_data_o, 12'hFFF);
    step(0, 0, 0, 1, 0);
    check("R3 locked cfg no write", wr_en_o, 0);
    step(0, 1, 0, 0, 0);
    check("R2 top wraps to 0", addr_o, 12'h000);

    step(0, 1, 1, 0, 12'h999);
    check("R10 inc beats load", addr_o, 12'h001);
    step(0, 0, 0, 1, 0);
    check("R10 write after collision", wr_en_o, 1);
    check("R10 load dropped slot0", wr_data_o[11:0], 12'hFFF);
    check("R8 slot1 blank", wr_data_o[23:12], 12'hFFF);
    step(1, 1, 0, 0, 0);
    check("R10 enter beats inc", addr_o, 12'hFFF);
    check("R1 cfg unlocked after enter", rd_data_o, 12'h3C1);

    step(0, 1, 0, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run addr", addr_o, 12'hFFF);
    check("R1 reset unlocks cfg", rd_data_o, 12'h3C1);

    step(0, 0, 1, 0, 12'h0AA);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    check("R6 cfg word mask", wr_mask_o, 4'b1000);
    check("R1 enter blanks buffer", wr_data_o[47:36], 12'hFFF);

    finish_run();
  end

endmodule